// File: doc/BRIEF.md
# BCD calendar clock with alarm

This core keeps wall-clock time for a system that only sees it through a byte-wide register port. Seconds, minutes, hours, day of month, month, two-digit year and weekday are held in packed BCD and move forward on a one-cycle tick input that pulses once per second. Software stops the counters with a run bit while it rewrites them. It takes a coherent copy of the time with a snapshot bit, and it is notified through a single level interrupt line.

Two interrupt sources share that line. An alarm fires when seconds through years equal a programmed set of alarm fields. A periodic timer fires on the second, minute, hour or day boundary chosen by software. Each source leaves a sticky status flag that software clears by writing 1 to it. The drift compensation word and the rounding and compensation control bits are plain storage. Counting is always 24-hour: the 12/24-hour bit is stored and read back only.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time fields at offsets 0x00..0x06 read 00,00,00,01,01,00,00 (second, minute, hour, day, month, year, weekday). The control register at 0x0D reads 0x00, the status register at 0x0E reads 0x80 (only the power-up flag, bit 7, set) and `irq` is low.
- R2: While control bit 0 (run) is 0, `sec_tick` pulses leave the time unchanged. A write to any offset 0x00..0x06 takes effect in the cycle it is issued, and a tick in that same cycle is dropped.
- R3: While running, each tick advances the seconds in BCD (09 to 10). 59 wraps to 00 and carries into the minutes, minutes 59 wrap with a carry into the hours, and hours 23 wrap to 00 with a carry into the day and the weekday. The weekday wraps 6 to 0.
- R4: The day wraps to 01 past 31 for months 01,03,05,07,08,10,12 and past 30 for months 04,06,09,11. For month 02 it wraps past 29 when the year value is divisible by 4 and past 28 otherwise. A day wrap advances the month, month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R5: Writing the control register with bit 6 = 1 copies offsets 0x00..0x05 into a frozen copy. Reads of 0x00..0x05 return that copy while counting continues, until the control register is written with bit 6 = 0. Bit 6 always reads 0.
- R6: Status bit 1 reads the run bit. Bits 2,3,4,5 are set on a tick while running, on a tick that wraps the seconds, on a tick that wraps the minutes, and on a tick that wraps the hours, respectively. Bits 2..7 clear when written with 1, and writing 0 leaves them unchanged.
- R7: Alarm fields at offsets 0x07..0x0C (second through year, same BCD format) are read and written there. Status bit 6 is set in the cycle after the live second..year fields all equal them.
- R8: The interrupt enable register at 0x0F holds a period select in bits 1:0 (00 second, 01 minute, 10 hour, 11 day), a timer enable in bit 2 and an alarm enable in bit 3, with bits 7:4 reading 0. `irq` is high exactly while (status bit 6 and bit 3) or (the status event flag chosen by bits 1:0, and bit 2).
- R9: Control bits 1, 2 and 3 and the compensation bytes at 0x10 (low) and 0x11 (high) read back as written and do not change counting, which stays 24-hour. Offsets 0x12 and above read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A broken carry or month-length decode shows up only at a boundary: the first tick after 59, 23, the last day of the month or year 99. The bench therefore sets the clock just before each boundary and reads the fields one tick later, so the fault is visible within two ticks. A wrong alarm comparison or status flag shows on `irq` and on status bit 6 one cycle after the matching tick. A snapshot that fails to freeze shows as a seconds read that moved, after three ticks.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  output logic [7:0]        rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_AL0  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_ALN  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] A_CMPL = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_CMPH = ADDR_W'(17);

  logic [7:0] tm [0:6];
  logic [7:0] sh [0:5];
  logic [7:0] al [0:5];
  logic [3:0] ctrl;
  logic       frozen;
  logic [3:0] st_ev;
  logic       st_al, st_pu;
  logic [3:0] ien;
  logic [7:0] cmp_lo, cmp_hi;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v, input logic [7:0] top,
                                         input logic [7:0] bottom);
    if (v >= top) return bottom;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  logic       time_wr, tick_go, c_sec, c_min, c_hr, c_day, c_mon, match, leap;
  logic [6:0] yr_bin;
  logic [7:0] dmax;
  logic [7:0] clr;
  logic [2:0] al_idx;

  assign time_wr = wr_en && (addr <= A_WDAY);
  assign tick_go = sec_tick && ctrl[0] && !time_wr;
  assign yr_bin  = 7'(tm[5][7:4]) * 7'd10 + 7'(tm[5][3:0]);
  assign leap    = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (tm[4])
      8'h02:                      dmax = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dmax = 8'h30;
      default:                    dmax = 8'h31;
    endcase
  end

  assign c_sec  = tm[0] >= 8'h59;
  assign c_min  = c_sec && (tm[1] >= 8'h59);
  assign c_hr   = c_min && (tm[2] >= 8'h23);
  assign c_day  = c_hr && (tm[3] >= dmax);
  assign c_mon  = c_day && (tm[4] >= 8'h12);
  assign match  = (tm[0] == al[0]) && (tm[1] == al[1]) && (tm[2] == al[2]) &&
                  (tm[3] == al[3]) && (tm[4] == al[4]) && (tm[5] == al[5]);
  assign clr    = (wr_en && addr == A_STAT) ? wdata : 8'h00;
  assign al_idx = 3'(addr - A_AL0);
  assign irq    = (st_al && ien[3]) || (st_ev[ien[1:0]] && ien[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm[0] <= 8'h00; tm[1] <= 8'h00; tm[2] <= 8'h00; tm[3] <= 8'h01;
      tm[4] <= 8'h01; tm[5] <= 8'h00; tm[6] <= 8'h00;
      for (int i = 0; i < 6; i++) begin
        sh[i] <= 8'h00;
        al[i] <= 8'h00;
      end
      ctrl <= '0; frozen <= 1'b0; ien <= '0;
      cmp_lo <= '0; cmp_hi <= '0;
      st_ev <= '0; st_al <= 1'b0; st_pu <= 1'b1;
    end else begin
      if (time_wr) tm[addr[2:0]] <= wdata;
      if (wr_en && addr >= A_AL0 && addr <= A_ALN) al[al_idx] <= wdata;
      if (wr_en && addr == A_CTRL) begin
        ctrl   <= wdata[3:0];
        frozen <= wdata[6];
        if (wdata[6])
          for (int i = 0; i < 6; i++) sh[i] <= tm[i];
      end
      if (wr_en && addr == A_IEN)  ien    <= wdata[3:0];
      if (wr_en && addr == A_CMPL) cmp_lo <= wdata;
      if (wr_en && addr == A_CMPH) cmp_hi <= wdata;

      if (tick_go) begin
        tm[0] <= bcd_inc(tm[0], 8'h59, 8'h00);
        if (c_sec) tm[1] <= bcd_inc(tm[1], 8'h59, 8'h00);
        if (c_min) tm[2] <= bcd_inc(tm[2], 8'h23, 8'h00);
        if (c_hr) begin
          tm[3] <= bcd_inc(tm[3], dmax, 8'h01);
          tm[6] <= bcd_inc(tm[6], 8'h06, 8'h00);
        end
        if (c_day) tm[4] <= bcd_inc(tm[4], 8'h12, 8'h01);
        if (c_mon) tm[5] <= bcd_inc(tm[5], 8'h99, 8'h00);
      end

      st_ev[0] <= (st_ev[0] && !clr[2]) || tick_go;
      st_ev[1] <= (st_ev[1] && !clr[3]) || (tick_go && c_sec);
      st_ev[2] <= (st_ev[2] && !clr[4]) || (tick_go && c_min);
      st_ev[3] <= (st_ev[3] && !clr[5]) || (tick_go && c_hr);
      st_al    <= (st_al && !clr[6]) || match;
      st_pu    <= st_pu && !clr[7];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr < A_WDAY)             rdata = frozen ? sh[addr[2:0]] : tm[addr[2:0]];
    else if (addr == A_WDAY)       rdata = tm[6];
    else if (addr <= A_ALN)        rdata = al[al_idx];
    else if (addr == A_CTRL)       rdata = {4'h0, ctrl};
    else if (addr == A_STAT)       rdata = {st_pu, st_al, st_ev, ctrl[0], 1'b0};
    else if (addr == A_IEN)        rdata = {4'h0, ien};
    else if (addr == A_CMPL)       rdata = cmp_lo;
    else if (addr == A_CMPH)       rdata = cmp_hi;
  end

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !time_wr) |=> $stable(tm[0]) && $stable(tm[1])); // R2
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && tm[0] == 8'h59) |=> (tm[0] == 8'h00)); // R3
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !(wr_en && addr == A_CTRL)) |=> $stable(sh[0]) && $stable(sh[5])); // R5
  AST_PWR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pu && !(wr_en && addr == A_STAT && wdata[7])) |=> st_pu); // R6
  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> st_al); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien[2] && !ien[3]) |-> !irq); // R8
endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0;
  logic [7:0] rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .irq(irq));

  task automatic check(input string req, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1;
    check(req, $sformatf("reg %h", a), rdata, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                          input logic [7:0] w);
    wr(8'h00, s); wr(8'h01, m); wr(8'h02, h); wr(8'h03, d);
    wr(8'h04, mo); wr(8'h05, y); wr(8'h06, w);
  endtask

  task automatic t_reset;
    rd_chk("R1", 8'h00, 8'h00); rd_chk("R1", 8'h01, 8'h00); rd_chk("R1", 8'h02, 8'h00);
    rd_chk("R1", 8'h03, 8'h01); rd_chk("R1", 8'h04, 8'h01); rd_chk("R1", 8'h05, 8'h00);
    rd_chk("R1", 8'h06, 8'h00); rd_chk("R1", 8'h0D, 8'h00); rd_chk("R1", 8'h0E, 8'h80);
    check("R1", "irq", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_stopped;
    tick(3);
    rd_chk("R2", 8'h00, 8'h00);
    rd_chk("R6", 8'h0E, 8'h80);
  endtask

  task automatic t_count;
    wr(8'h0D, 8'h01);
    wr(8'h0E, 8'h80);
    rd_chk("R6", 8'h0E, 8'h02);
    wr(8'h00, 8'h08);
    tick(2);
    rd_chk("R3", 8'h00, 8'h10);
    set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h06);
    wr(8'h0E, 8'hFC);
    tick(2);
    rd_chk("R3", 8'h00, 8'h00); rd_chk("R3", 8'h01, 8'h00); rd_chk("R3", 8'h02, 8'h00);
    rd_chk("R3", 8'h06, 8'h00);
    rd_chk("R4", 8'h03, 8'h01); rd_chk("R4", 8'h04, 8'h03);
    rd_chk("R6", 8'h0E, 8'h3E);
    wr(8'h0E, 8'h00);
    rd_chk("R6", 8'h0E, 8'h3E);
    wr(8'h0E, 8'h3C);
    rd_chk("R6", 8'h0E, 8'h02);
  endtask

  task automatic t_calendar;
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h02);
    tick(1);
    rd_chk("R4", 8'h03, 8'h29); rd_chk("R4", 8'h04, 8'h02);
    wr(8'h00, 8'h59); wr(8'h01, 8'h59); wr(8'h02, 8'h23);
    tick(1);
    rd_chk("R4", 8'h03, 8'h01); rd_chk("R4", 8'h04, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h25, 8'h01);
    tick(1);
    rd_chk("R4", 8'h03, 8'h01); rd_chk("R4", 8'h04, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h03);
    tick(1);
    rd_chk("R4", 8'h03, 8'h01); rd_chk("R4", 8'h04, 8'h01); rd_chk("R4", 8'h05, 8'h00);
    rd_chk("R3", 8'h06, 8'h04);
  endtask

  task automatic t_write_priority;
    set_time(8'h05, 8'h10, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    @(negedge clk);
    addr = '0; wdata = 8'h40; wr_en = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
    rd_chk("R2", 8'h00, 8'h40);
    rd_chk("R2", 8'h01, 8'h10);
  endtask

  task automatic t_snapshot;
    wr(8'h00, 8'h10);
    wr(8'h0D, 8'h41);
    rd_chk("R5", 8'h0D, 8'h01);
    tick(3);
    rd_chk("R5", 8'h00, 8'h10);
    wr(8'h0D, 8'h01);
    rd_chk("R5", 8'h00, 8'h13);
  endtask

  task automatic t_alarm;
    wr(8'h0D, 8'h00);
    set_time(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h25, 8'h02);
    wr(8'h07, 8'h31); wr(8'h08, 8'h20); wr(8'h09, 8'h10);
    wr(8'h0A, 8'h15); wr(8'h0B, 8'h06); wr(8'h0C, 8'h25);
    rd_chk("R7", 8'h07, 8'h31);
    wr(8'h0E, 8'hFC);
    wr(8'h0F, 8'h08);
    check("R8", "irq before match", {7'h0, irq}, 8'h00);
    wr(8'h0D, 8'h01);
    tick(1);
    @(negedge clk);
    check("R8", "irq on alarm", {7'h0, irq}, 8'h01);
    rd_chk("R7", 8'h0E, 8'h46);
    wr(8'h0F, 8'hF0);
    rd_chk("R8", 8'h0F, 8'h00);
    check("R8", "irq alarm disabled", {7'h0, irq}, 8'h00);
    wr(8'h0F, 8'h08);
    check("R8", "irq re-enabled", {7'h0, irq}, 8'h01);
    wr(8'h07, 8'h00);
    wr(8'h0E, 8'hFC);
    check("R6", "irq after clear", {7'h0, irq}, 8'h00);
    rd_chk("R6", 8'h0E, 8'h02);
  endtask

  task automatic t_periodic;
    wr(8'h0F, 8'h05);
    tick(1);
    check("R8", "irq minute period", {7'h0, irq}, 8'h00);
    wr(8'h0F, 8'h04);
    check("R8", "irq second period", {7'h0, irq}, 8'h01);
    rd_chk("R6", 8'h0E, 8'h06);
    wr(8'h0E, 8'h04);
    check("R8", "irq after event clear", {7'h0, irq}, 8'h00);
    wr(8'h0F, 8'h00);
  endtask

  task automatic t_storage;
    wr(8'h0D, 8'h0F);
    rd_chk("R9", 8'h0D, 8'h0F);
    wr(8'h10, 8'hA5); wr(8'h11, 8'h5A);
    rd_chk("R9", 8'h10, 8'hA5); rd_chk("R9", 8'h11, 8'h5A);
    rd_chk("R9", 8'h12, 8'h00); rd_chk("R9", 8'h1F, 8'h00);
    set_time(8'h59, 8'h59, 8'h12, 8'h10, 8'h10, 8'h10, 8'h01);
    tick(1);
    rd_chk("R9", 8'h02, 8'h13);
    rd_chk("R9", 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_stopped;
    t_count;
    t_calendar;
    t_write_priority;
    t_snapshot;
    t_alarm;
    t_periodic;
    t_storage;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule